// File: doc/BRIEF.md
# Character LCD Power-Up and Write Controller

This block sits between a host and a character LCD module of the common parallel type. After reset it keeps the display bus idle for the power-settling time. It then plays a fixed start-up program: bus width and two-line set-up, display on, clear, and cursor auto-increment. After that it accepts one host byte per valid/ready handshake. Every transfer on the LCD side is a strobe: data and register select are set up first, then the enable line pulses, then everything is held. After each instruction the controller waits the minimum time it needs before the next one. All of these times come from a clock-frequency parameter and are rounded up.

A second parameter picks the bus width. With the full byte-wide bus, each instruction is a single strobe on DB[7:0]. With the narrow bus, data travels on DB[7:4] with DB[3:0] held at zero. Each byte is then sent as two strobes, high nibble first. Start-up in narrow mode begins with one lone nibble that switches the display to that width.

A host request can carry a raw byte with its register-select bit. It can also ask for a cursor move: the block builds the address instruction itself from a line bit and a column.

Top module: `lcd_init_ctrl`

## Requirements
- R1: After reset release, `lcd_en` stays low and `req_ready` stays low for at least ceil(0.030 × CLK_HZ) clock cycles before the first enable pulse.
- R2: With WIDE_BUS=1, the start-up program puts exactly four instructions on DB[7:0], all with RS=0, in this order: 0x38, 0x0E, 0x01, 0x06.
- R3: With WIDE_BUS=0, the start-up program sends nibbles on DB[7:4] with DB[3:0]=0 and RS=0, in this order: 2 (lone), 2, 8, 0, E, 0, 1, 0, 6. The last eight nibbles are the instructions 0x28, 0x0E, 0x01 and 0x06.
- R4: Between the last strobe of one instruction and the next enable rise, enable stays low for at least ceil(1.53 ms × CLK_HZ) cycles after an instruction byte 0x01 or 0x02 with RS=0. After any other instruction, data byte, or the lone nibble, the minimum is ceil(39 µs × CLK_HZ) cycles.
- R5: Each enable pulse lasts at least max(1, ceil(1 µs × CLK_HZ)) cycles. DB and RS hold their value from at least one cycle before the enable rise until the cycle after the enable fall.
- R6: `lcd_rw` is 0 at all times.
- R7: `req_ready` is low until the start-up program and its final wait have finished. A request held valid during start-up causes no transfer before then, and it is accepted exactly once when `req_ready` first rises.
- R8: A request is accepted on a clock edge where `req_valid` and `req_ready` are both high. It is sent with RS equal to `req_rs` and the byte `req_data`. `req_ready` is low in the cycle after acceptance and stays low until the wait after that byte has ended.
- R9: When `req_pos`=1, the block sends RS=0 and the byte 0x80 + 0x40×`req_line` + `req_col`. `req_data` and `req_rs` have no effect, and this byte never takes the long wait.
- R10: With WIDE_BUS=0, each host byte goes out as two strobes on DB[7:4]: bits 7:4 first, then bits 3:0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, CLK_HZ |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Host request present |
| req_ready | output | 1 | Controller can take a request |
| req_rs | input | 1 | Register select for a raw byte (1 = character data) |
| req_data | input | 8 | Raw byte to write |
| req_pos | input | 1 | Request is a cursor move built from line and column |
| req_line | input | 1 | Cursor line (0 = first, 1 = second) |
| req_col | input | 4 | Cursor column 0..15 |
| lcd_rs | output | 1 | LCD register select |
| lcd_rw | output | 1 | LCD read/write, always write |
| lcd_en | output | 1 | LCD enable strobe |
| lcd_db | output | 8 | LCD data bus (narrow mode uses bits 7:4) |

## Verification
The end of start-up and a pending host request can fall in the same cycle. The bench provokes this by raising `req_valid` on both bus-width instances while reset is still active and leaving it high. The request must then produce exactly one transfer, placed right after the start-up strobes. `req_ready` must not have been seen high before the entry-mode wait ran out. The bench also drives cursor requests with conflicting raw fields, RS=1 and byte 0x01, in the same request. The emitted byte and its wait must follow only the line and column.

// File: rtl/lcd_pkg.sv
package lcd_pkg;

    typedef enum logic [1:0] {
        XF_IDLE,
        XF_SETUP,
        XF_PULSE,
        XF_HOLD
    } xfer_state_e;

    typedef enum logic [1:0] {
        SQ_POWER,
        SQ_SEND,
        SQ_WAIT,
        SQ_READY
    } seq_state_e;

    // one entry of the start-up program
    typedef struct packed {
        logic [7:0] code;
        logic       lone;   // narrow bus: send the upper nibble only
        logic       slow;   // long settle after this entry
    } step_t;

    localparam logic [7:0] CMD_CLEAR  = 8'h01;
    localparam logic [7:0] CMD_HOME   = 8'h02;
    localparam logic [7:0] CMD_SETPOS = 8'h80;

    function automatic longint ceil_div(longint num, longint den);
        return (num + den - 1) / den;
    endfunction

    function automatic step_t script_step(logic wide, int idx);
        step_t s;
        int    j;
        s = '{code: 8'h00, lone: 1'b0, slow: 1'b0};
        if (wide) begin
            j = idx + 1;
        end else begin
            j = idx;
        end
        case (j)
            0: s = '{code: 8'h20, lone: 1'b1, slow: 1'b0};
            1: s = '{code: (wide ? 8'h38 : 8'h28), lone: 1'b0, slow: 1'b0};
            2: s = '{code: 8'h0E, lone: 1'b0, slow: 1'b0};
            3: s = '{code: CMD_CLEAR, lone: 1'b0, slow: 1'b1};
            4: s = '{code: 8'h06, lone: 1'b0, slow: 1'b0};
            default: s = '{code: 8'h00, lone: 1'b0, slow: 1'b0};
        endcase
        return s;
    endfunction

endpackage

// File: rtl/lcd_timer.sv
module lcd_timer #(
    parameter int W     = 16,
    parameter int START = 0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] count,
    output logic         expired
);

    typedef struct packed {
        logic [W-1:0] cnt;
    } tmr_t;

    tmr_t r_d, r_q;

    always_comb begin
        r_d = r_q;
        if (load) begin
            r_d.cnt = count;
        end else if (r_q.cnt != '0) begin
            r_d.cnt = r_q.cnt - 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '{cnt: W'(START)};
        end else begin
            r_q <= r_d;
        end
    end

    assign expired = (r_q.cnt == '0);

endmodule

// File: rtl/lcd_strobe.sv
module lcd_strobe
    import lcd_pkg::*;
#(
    parameter bit WIDE   = 1'b1,
    parameter int EN_CYC = 1
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       start,
    input  logic       rs_in,
    input  logic [7:0] code_in,
    input  logic       lone_in,
    output logic       done,
    output logic       lcd_rs,
    output logic       lcd_en,
    output logic [7:0] lcd_db
);

    localparam int EW = (EN_CYC > 1) ? $clog2(EN_CYC) : 1;

    typedef struct packed {
        xfer_state_e   st;
        logic          rs;
        logic [7:0]    code;
        logic          lone;
        logic          low_half;
        logic [EW-1:0] cnt;
    } xf_t;

    xf_t  r_d, r_q;
    logic last_half;

    always_comb begin
        r_d       = r_q;
        done      = 1'b0;
        last_half = WIDE || r_q.lone || r_q.low_half;
        unique case (r_q.st)
            XF_IDLE: begin
                if (start) begin
                    r_d.st       = XF_SETUP;
                    r_d.rs       = rs_in;
                    r_d.code     = code_in;
                    r_d.lone     = lone_in;
                    r_d.low_half = 1'b0;
                end
            end
            XF_SETUP: begin
                r_d.st  = XF_PULSE;
                r_d.cnt = EW'(EN_CYC - 1);
            end
            XF_PULSE: begin
                if (r_q.cnt == '0) begin
                    r_d.st = XF_HOLD;
                end else begin
                    r_d.cnt = r_q.cnt - 1'b1;
                end
            end
            XF_HOLD: begin
                if (last_half) begin
                    done   = 1'b1;
                    r_d.st = XF_IDLE;
                end else begin
                    r_d.low_half = 1'b1;
                    r_d.st       = XF_SETUP;
                end
            end
            default: r_d.st = XF_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    assign lcd_en = (r_q.st == XF_PULSE);
    assign lcd_rs = r_q.rs;

    generate
        if (WIDE) begin : g_byte_bus
            assign lcd_db = r_q.code;
        end else begin : g_nibble_bus
            assign lcd_db = {(r_q.low_half ? r_q.code[3:0] : r_q.code[7:4]), 4'b0000};
        end
    endgenerate

    // pulse width observer for the checks below
    int wid_q;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wid_q <= 0;
        end else if (lcd_en) begin
            wid_q <= (wid_q < EN_CYC) ? wid_q + 1 : wid_q;
        end else begin
            wid_q <= 0;
        end
    end

    assert_start_idle_R5: assert property (@(posedge clk) disable iff (!rst_n)
        start |-> (r_q.st == XF_IDLE));

    assert_setup_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(lcd_en) |-> ($stable(lcd_db) && $stable(lcd_rs)));

    assert_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(lcd_en) |-> ($stable(lcd_db) && $stable(lcd_rs)));

    assert_width_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(lcd_en) |-> (wid_q >= EN_CYC));

endmodule

// File: rtl/lcd_seq.sv
module lcd_seq
    import lcd_pkg::*;
#(
    parameter bit WIDE    = 1'b1,
    parameter int TW      = 16,
    parameter int T_SHORT = 39,
    parameter int T_LONG  = 1530
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          req_valid,
    input  logic          req_rs,
    input  logic [7:0]    req_data,
    input  logic          req_pos,
    input  logic          req_line,
    input  logic [3:0]    req_col,
    output logic          req_ready,
    input  logic          xf_done,
    input  logic          tmr_expired,
    output logic          xf_start,
    output logic          xf_rs,
    output logic [7:0]    xf_code,
    output logic          xf_lone,
    output logic          tmr_load,
    output logic [TW-1:0] tmr_count
);

    localparam int NSTEP = WIDE ? 4 : 5;
    localparam int IW    = $clog2(NSTEP);

    typedef struct packed {
        seq_state_e    st;
        logic [IW-1:0] idx;
        logic          slow;
        logic          booted;
    } sq_t;

    sq_t        r_d, r_q;
    step_t      cur_step, nxt_step;
    logic [7:0] host_code;
    logic       host_rs;

    always_comb begin
        r_d       = r_q;
        xf_start  = 1'b0;
        xf_rs     = 1'b0;
        xf_code   = 8'h00;
        xf_lone   = 1'b0;
        tmr_load  = 1'b0;
        tmr_count = '0;
        cur_step  = script_step(WIDE, int'(r_q.idx));
        nxt_step  = script_step(WIDE, int'(r_q.idx) + 1);
        host_code = req_pos ? (CMD_SETPOS | {1'b0, req_line, 2'b00, req_col}) : req_data;
        host_rs   = req_pos ? 1'b0 : req_rs;
        unique case (r_q.st)
            SQ_POWER: begin
                if (tmr_expired) begin
                    xf_start = 1'b1;
                    xf_code  = cur_step.code;
                    xf_lone  = cur_step.lone;
                    r_d.slow = cur_step.slow;
                    r_d.st   = SQ_SEND;
                end
            end
            SQ_SEND: begin
                if (xf_done) begin
                    tmr_load  = 1'b1;
                    tmr_count = r_q.slow ? TW'(T_LONG) : TW'(T_SHORT);
                    r_d.st    = SQ_WAIT;
                end
            end
            SQ_WAIT: begin
                if (tmr_expired) begin
                    if (r_q.booted || (r_q.idx == IW'(NSTEP - 1))) begin
                        r_d.booted = 1'b1;
                        r_d.st     = SQ_READY;
                    end else begin
                        xf_start = 1'b1;
                        xf_code  = nxt_step.code;
                        xf_lone  = nxt_step.lone;
                        r_d.slow = nxt_step.slow;
                        r_d.idx  = r_q.idx + 1'b1;
                        r_d.st   = SQ_SEND;
                    end
                end
            end
            SQ_READY: begin
                if (req_valid) begin
                    xf_start = 1'b1;
                    xf_code  = host_code;
                    xf_rs    = host_rs;
                    r_d.slow = !host_rs && ((host_code == CMD_CLEAR) || (host_code == CMD_HOME));
                    r_d.st   = SQ_SEND;
                end
            end
            default: r_d.st = SQ_POWER;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    assign req_ready = (r_q.st == SQ_READY);

    assert_ready_after_wait_R8: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |-> tmr_expired);

    assert_accept_drops_ready_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> !req_ready);

    assert_no_wait_cut_R4: assert property (@(posedge clk) disable iff (!rst_n)
        tmr_load |-> tmr_expired);

endmodule

// File: rtl/lcd_init_ctrl.sv
module lcd_init_ctrl #(
    parameter int unsigned CLK_HZ   = 50_000_000,
    parameter bit          WIDE_BUS = 1'b1
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       req_valid,
    output logic       req_ready,
    input  logic       req_rs,
    input  logic [7:0] req_data,
    input  logic       req_pos,
    input  logic       req_line,
    input  logic [3:0] req_col,
    output logic       lcd_rs,
    output logic       lcd_rw,
    output logic       lcd_en,
    output logic [7:0] lcd_db
);

    localparam longint CLK_L   = longint'(CLK_HZ);
    localparam int     EN_RAW  = int'(lcd_pkg::ceil_div(CLK_L, 64'd1_000_000));
    localparam int     EN_CYC  = (EN_RAW < 1) ? 1 : EN_RAW;
    localparam int     T_PWR   = int'(lcd_pkg::ceil_div(CLK_L * 3, 64'd100));
    localparam int     T_SHORT = int'(lcd_pkg::ceil_div(CLK_L * 39, 64'd1_000_000));
    localparam int     T_LONG  = int'(lcd_pkg::ceil_div(CLK_L * 153, 64'd100_000));
    localparam int     TW      = $clog2(T_PWR + 1);

    logic          xf_start, xf_rs, xf_lone, xf_done;
    logic [7:0]    xf_code;
    logic          tmr_load, tmr_expired;
    logic [TW-1:0] tmr_count;

    lcd_timer #(
        .W     (TW),
        .START (T_PWR)
    ) u_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (tmr_load),
        .count   (tmr_count),
        .expired (tmr_expired)
    );

    lcd_seq #(
        .WIDE    (WIDE_BUS),
        .TW      (TW),
        .T_SHORT (T_SHORT),
        .T_LONG  (T_LONG)
    ) u_seq (
        .clk         (clk),
        .rst_n       (rst_n),
        .req_valid   (req_valid),
        .req_rs      (req_rs),
        .req_data    (req_data),
        .req_pos     (req_pos),
        .req_line    (req_line),
        .req_col     (req_col),
        .req_ready   (req_ready),
        .xf_done     (xf_done),
        .tmr_expired (tmr_expired),
        .xf_start    (xf_start),
        .xf_rs       (xf_rs),
        .xf_code     (xf_code),
        .xf_lone     (xf_lone),
        .tmr_load    (tmr_load),
        .tmr_count   (tmr_count)
    );

    lcd_strobe #(
        .WIDE   (WIDE_BUS),
        .EN_CYC (EN_CYC)
    ) u_xfer (
        .clk     (clk),
        .rst_n   (rst_n),
        .start   (xf_start),
        .rs_in   (xf_rs),
        .code_in (xf_code),
        .lone_in (xf_lone),
        .done    (xf_done),
        .lcd_rs  (lcd_rs),
        .lcd_en  (lcd_en),
        .lcd_db  (lcd_db)
    );

    assign lcd_rw = 1'b0;

endmodule

// File: tb/lcd_init_ctrl_bench.sv
module lcd_init_ctrl_bench;

    localparam int unsigned CLK_HZ = 1_000_000;
    localparam int EN_MIN    = (CLK_HZ + 999_999) / 1_000_000;
    localparam int PWR_MIN   = (CLK_HZ * 3 + 99) / 100;
    localparam int SHORT_MIN = (CLK_HZ * 39 + 999_999) / 1_000_000;
    localparam int LONG_MIN  = (CLK_HZ * 153 + 99_999) / 100_000;
    localparam int NV        = 9;

    // {pos, rs, line, col[3:0], data[7:0], exp_code[7:0], exp_rs, slow}
    localparam logic [24:0] VEC [NV] = '{
        {1'b0, 1'b1, 1'b0, 4'h0, 8'h41, 8'h41, 1'b1, 1'b0},
        {1'b0, 1'b0, 1'b0, 4'h0, 8'h01, 8'h01, 1'b0, 1'b1},
        {1'b1, 1'b1, 1'b0, 4'h5, 8'hFF, 8'h85, 1'b0, 1'b0},
        {1'b1, 1'b0, 1'b1, 4'hF, 8'h00, 8'hCF, 1'b0, 1'b0},
        {1'b0, 1'b0, 1'b0, 4'h0, 8'h02, 8'h02, 1'b0, 1'b1},
        {1'b0, 1'b1, 1'b0, 4'h0, 8'h01, 8'h01, 1'b1, 1'b0},
        {1'b0, 1'b0, 1'b0, 4'h0, 8'h0C, 8'h0C, 1'b0, 1'b0},
        {1'b0, 1'b1, 1'b0, 4'h0, 8'h7E, 8'h7E, 1'b1, 1'b0},
        {1'b1, 1'b1, 1'b1, 4'h0, 8'h01, 8'hC0, 1'b0, 1'b0}
    };

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic [1:0]      req_valid = 2'b00;
    logic [1:0]      req_ready;
    logic            req_rs = 1'b0, req_pos = 1'b0, req_line = 1'b0;
    logic [7:0]      req_data = 8'h00;
    logic [3:0]      req_col = 4'h0;
    logic [1:0]      en_w, rs_w, rw_w;
    logic [1:0][7:0] db_w;

    always #4 clk = ~clk;

    lcd_init_ctrl #(.CLK_HZ(CLK_HZ), .WIDE_BUS(1'b1)) u_lcd_init_ctrl (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid[0]), .req_ready(req_ready[0]),
        .req_rs(req_rs), .req_data(req_data), .req_pos(req_pos), .req_line(req_line),
        .req_col(req_col), .lcd_rs(rs_w[0]), .lcd_rw(rw_w[0]), .lcd_en(en_w[0]), .lcd_db(db_w[0])
    );

    lcd_init_ctrl #(.CLK_HZ(CLK_HZ), .WIDE_BUS(1'b0)) u_lcd_init_ctrl_nib (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid[1]), .req_ready(req_ready[1]),
        .req_rs(req_rs), .req_data(req_data), .req_pos(req_pos), .req_line(req_line),
        .req_col(req_col), .lcd_rs(rs_w[1]), .lcd_rw(rw_w[1]), .lcd_en(en_w[1]), .lcd_db(db_w[1])
    );

    int tests = 0, fails = 0;
    bit finished = 1'b0;

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // ---------------- monitor ----------------
    int cyc = 0, rel_cyc = 0, rw_high = 0;
    int first_ready [2] = '{-1, -1};
    int n_ev [2] = '{0, 0};
    int ev_rise [2][64], ev_fall [2][64];
    logic [7:0] ev_db [2][64];
    logic ev_rs [2][64], ev_setup [2][64], ev_hold [2][64], ev_stab [2][64];
    logic [1:0] en_p = 2'b00, rs_p = 2'b00;
    logic [1:0][7:0] db_p = '0;

    always @(posedge clk) cyc <= cyc + 1;

    always @(negedge clk) begin
        if (rst_n) begin
            for (int k = 0; k < 2; k++) begin
                if (rw_w[k]) rw_high++;
                if (req_ready[k] && first_ready[k] < 0) first_ready[k] = cyc;
                if (n_ev[k] < 64) begin
                    if (en_w[k] && !en_p[k]) begin
                        ev_rise[k][n_ev[k]]  = cyc;
                        ev_setup[k][n_ev[k]] = (db_w[k] == db_p[k]) && (rs_w[k] == rs_p[k]);
                        ev_stab[k][n_ev[k]]  = 1'b1;
                    end else if (en_w[k] && en_p[k]) begin
                        if (db_w[k] != db_p[k] || rs_w[k] != rs_p[k]) ev_stab[k][n_ev[k]] = 1'b0;
                    end else if (!en_w[k] && en_p[k]) begin
                        ev_fall[k][n_ev[k]] = cyc;
                        ev_db[k][n_ev[k]]   = db_p[k];
                        ev_rs[k][n_ev[k]]   = rs_p[k];
                        ev_hold[k][n_ev[k]] = (db_w[k] == db_p[k]) && (rs_w[k] == rs_p[k]);
                        n_ev[k]++;
                    end
                end
            end
        end
        en_p = en_w;
        rs_p = rs_w;
        db_p = db_w;
    end

    // ---------------- expected transfers ----------------
    int n_exp [2] = '{0, 0};
    logic [7:0] ex_db [2][64];
    logic ex_rs [2][64];
    int ex_gap [2][64];
    string ex_tag [2][64];

    task automatic add_xfer(input int k, input logic [7:0] db, input logic rs,
                            input int gap, input string tag);
        if (n_exp[k] < 64) begin
            ex_db[k][n_exp[k]]  = db;
            ex_rs[k][n_exp[k]]  = rs;
            ex_gap[k][n_exp[k]] = gap;
            ex_tag[k][n_exp[k]] = tag;
            n_exp[k]++;
        end
    endtask

    task automatic expect_instr(input int k, input logic [7:0] code, input logic rs,
                                input bit slow, input string tag);
        int gap;
        gap = slow ? LONG_MIN : SHORT_MIN;
        if (k == 0) begin
            add_xfer(k, code, rs, gap, tag);
        end else begin
            add_xfer(k, {code[7:4], 4'h0}, rs, 0, tag);   // R10 high nibble first
            add_xfer(k, {code[3:0], 4'h0}, rs, gap, tag);
        end
    endtask

    task automatic grab_held(input int k);
        while (!req_ready[k]) @(negedge clk);
        @(negedge clk);
        req_valid[k] = 1'b0;
        check(req_ready[k] == 1'b0, "R7", "held request taken once", int'(req_ready[k]), 0);
    endtask

    task automatic host_write(input int k, input logic [24:0] v);
        while (!req_ready[k]) @(negedge clk);
        req_pos   = v[24];
        req_rs    = v[23];
        req_line  = v[22];
        req_col   = v[21:18];
        req_data  = v[17:10];
        req_valid[k] = 1'b1;
        @(negedge clk);
        req_valid[k] = 1'b0;
        check(req_ready[k] == 1'b0, "R8", "ready low after accept", int'(req_ready[k]), 0);
    endtask

    // ---------------- watchdog ----------------
    initial begin
        repeat (200_000) @(posedge clk);
        if (!finished) begin
            tests++;
            fails++;
            $display("FAIL watchdog (R8 ready never returned): actual=timeout expected=finish");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    // ---------------- main ----------------
    initial begin
        string tag;
        int init_last;
        // request held valid through reset and start-up (R7)
        req_rs = 1'b1;
        req_data = 8'h5A;
        req_pos = 1'b0;
        req_valid = 2'b11;
        repeat (3) @(negedge clk);
        for (int k = 0; k < 2; k++) begin
            check(en_w[k] == 1'b0, "R1", "enable low in reset", int'(en_w[k]), 0);
            check(req_ready[k] == 1'b0, "R7", "ready low in reset", int'(req_ready[k]), 0);
        end
        rst_n = 1'b1;
        rel_cyc = cyc;

        // start-up programs
        expect_instr(0, 8'h38, 1'b0, 1'b0, "R2");
        expect_instr(0, 8'h0E, 1'b0, 1'b0, "R2");
        expect_instr(0, 8'h01, 1'b0, 1'b1, "R2");
        expect_instr(0, 8'h06, 1'b0, 1'b0, "R2");
        add_xfer(1, 8'h20, 1'b0, SHORT_MIN, "R3");
        expect_instr(1, 8'h28, 1'b0, 1'b0, "R3");
        expect_instr(1, 8'h0E, 1'b0, 1'b0, "R3");
        expect_instr(1, 8'h01, 1'b0, 1'b1, "R3");
        expect_instr(1, 8'h06, 1'b0, 1'b0, "R3");
        expect_instr(0, 8'h5A, 1'b1, 1'b0, "R7");
        expect_instr(1, 8'h5A, 1'b1, 1'b0, "R7");

        fork
            grab_held(0);
            grab_held(1);
        join

        // table of host requests
        for (int k = 0; k < 2; k++) begin
            for (int i = 0; i < NV; i++) begin
                host_write(k, VEC[i]);
                if (VEC[i][24]) tag = "R9";
                else if (k == 1) tag = "R10";
                else tag = "R8";
                expect_instr(k, VEC[i][9:2], VEC[i][1], VEC[i][0], tag);
            end
        end
        while (req_ready != 2'b11) @(negedge clk);

        // final comparison
        for (int k = 0; k < 2; k++) begin
            init_last = (k == 0) ? 3 : 8;
            check(n_ev[k] == n_exp[k], (k == 0) ? "R2" : "R3", "transfer count", n_ev[k], n_exp[k]);
            check(n_ev[k] > 0 && (ev_rise[k][0] - rel_cyc) >= PWR_MIN, "R1",
                  "power-up wait", ev_rise[k][0] - rel_cyc, PWR_MIN);
            check(first_ready[k] >= ev_fall[k][init_last] + SHORT_MIN, "R7",
                  "ready after start-up", first_ready[k], ev_fall[k][init_last] + SHORT_MIN);
            for (int i = 0; i < n_ev[k] && i < n_exp[k]; i++) begin
                check(ev_db[k][i] == ex_db[k][i], ex_tag[k][i], "bus byte",
                      int'(ev_db[k][i]), int'(ex_db[k][i]));
                check(ev_rs[k][i] == ex_rs[k][i], ex_tag[k][i], "register select",
                      int'(ev_rs[k][i]), int'(ex_rs[k][i]));
                check((ev_fall[k][i] - ev_rise[k][i]) >= EN_MIN, "R5", "enable width",
                      ev_fall[k][i] - ev_rise[k][i], EN_MIN);
                check(ev_setup[k][i] && ev_hold[k][i] && ev_stab[k][i], "R5",
                      "setup/hold", int'({ev_setup[k][i], ev_hold[k][i], ev_stab[k][i]}), 7);
                if (i + 1 < n_ev[k]) begin
                    check((ev_rise[k][i+1] - ev_fall[k][i]) >= ex_gap[k][i], "R4",
                          "settle gap", ev_rise[k][i+1] - ev_fall[k][i], ex_gap[k][i]);
                end
            end
        end
        check(rw_high == 0, "R6", "write line stays low", rw_high, 0);

        finished = 1'b1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule